// File: doc/BRIEF.md
# Hardware Cursor Register Bank

This block is the register bank behind a display hardware cursor. A host writes 32-bit words into it through a simple write port. Each write lands in a pending copy of the cursor settings. The pixel pipeline reads a separate active copy, which drives the block's outputs. The settings are:

- the cursor on/off flag, colour mode, magnify flag and inverse-transparent clamp flag;
- the X/Y position and the X/Y hot spot;
- the width and height;
- two 24-bit colours;
- a 40-bit page-aligned surface base address.

Pending settings move to the active copy as a group. While the update-lock bit in the control word is set, nothing moves. The move happens on the first clock edge at which the lock is clear and at least one pending change exists, and a one-cycle strobe marks each such move. Software can therefore set the lock, reprogram several registers, and clear the lock, and the pipeline never sees a half-updated cursor.

The surface address is written in two halves, upper byte first. The lower-half write is what completes the address. The size is stored as each dimension minus one and presented as the true dimension.

Top module: `cursor_regbank`

## Requirements
- R1: In the cycle after a synchronous reset, every output is as follows. Enable, mode, magnify and clamp are 0. Position, hot spot, colours and surface address are 0. Width and height are 1, because the stored size fields are 0. The commit strobe is 0 and the lock is clear.
- R2: The control word is at offset 0. Its fields are:
  - bit 0: enable
  - bits 2:1: mode
  - bit 3: magnify
  - bit 4: inverse-transparent clamp
  - bit 8: update lock, which takes effect at once

  With the lock clear, a mapped write on clock edge k appears on the outputs after edge k+1, and `commit_stb` is high for exactly that one cycle. Outputs never change in a cycle without the strobe.
- R3: The mode field passes through unchanged. Its codes are 0 monochrome, 1 colour with 1-bit AND mask, 2 pre-multiplied alpha and 3 straight (non-pre-multiplied) alpha.
- R4: Position is at offset 1 and hot spot at offset 2. Each holds X in the low half-word and Y in the high half-word. Only the low 13 bits (position) or 7 bits (hot spot) of each half are kept.
- R5: The size register at offset 3 holds width-1 in bits 6:0 and height-1 in bits 22:16. The outputs are those fields plus one: a field of 0 gives 1, and a field of 127 gives 128.
- R6: The colour registers are at offsets 4 and 5. Each keeps bits 23:0 as {red[23:16], green[15:8], blue[7:0]} and presents them in that packing.
- R7: A write to the high address register (offset 6, bits 7:0 become address bits 39:32) is only staged. By itself it changes no output and raises no strobe, even with the lock clear.
- R8: A write to the low address register (offset 7) completes the address. The new address is {staged high byte, data[31:12], 12'h000}. Data bits 11:0 are ignored.
- R9: While the lock is set, writes to any register leave every output unchanged and raise no strobe.
- R10: A control write that clears the lock commits all changes pending since the lock was set. They appear together on the first edge after that write, with a single strobe.
- R11: A write that lands on the same edge as a commit is not lost. It is committed on the next edge, with a second strobe.
- R12: Writes to offsets 8 to 15 are ignored. They change no output, raise no strobe, and alter no pending value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Register word offset |
| wr_data | input | 32 | Write data |
| cur_enable | output | 1 | Active cursor enable |
| cur_mode | output | 2 | Active colour mode |
| cur_magnify | output | 1 | Active 2x magnify flag |
| cur_inv_clamp | output | 1 | Active inverse-transparent clamp flag |
| cur_pos_x | output | 13 | Active X position |
| cur_pos_y | output | 13 | Active Y position |
| cur_hot_x | output | 7 | Active hot spot X |
| cur_hot_y | output | 7 | Active hot spot Y |
| cur_width | output | 8 | Active width (stored field plus one) |
| cur_height | output | 8 | Active height (stored field plus one) |
| cur_color1 | output | 24 | Active first colour {R,G,B} |
| cur_color2 | output | 24 | Active second colour {R,G,B} |
| cur_surf_addr | output | 40 | Active surface base byte address |
| commit_stb | output | 1 | One-cycle pulse when the active copy is loaded |

## Verification
The collision that matters is a host write arriving on the same edge as a commit of an earlier write. Only the older value may be committed on that edge, and the newer one must still get committed after it.

The bench provokes this with two position writes on consecutive cycles while the lock is clear. It expects the first position together with a strobe, then the second position with another strobe one cycle later, then the strobe low.

A related overlap is a control write that clears the lock while also carrying new control fields. The bench judges that the fields of the releasing write itself are committed along with everything held during the lock, under one strobe.

// File: rtl/cursor_regbank_pkg.sv
package cursor_regbank_pkg;
  localparam int DATA_W    = 32;
  localparam int REG_AW    = 4;
  localparam int COORD_W   = 13;
  localparam int HOT_W     = 7;
  localparam int SIZE_W    = 7;
  localparam int COLOR_W   = 24;
  localparam int SURF_W    = 40;
  localparam int PAGE_BITS = 12;
  localparam int HALF      = DATA_W / 2;
  localparam int SURF_HI_W = SURF_W - DATA_W;
  localparam int LO_KEEP_W = DATA_W - PAGE_BITS;
  localparam int SURF_KEEP = SURF_W - PAGE_BITS;

  localparam logic [REG_AW-1:0] OFS_CTRL    = 4'd0;
  localparam logic [REG_AW-1:0] OFS_POS     = 4'd1;
  localparam logic [REG_AW-1:0] OFS_HOT     = 4'd2;
  localparam logic [REG_AW-1:0] OFS_SIZE    = 4'd3;
  localparam logic [REG_AW-1:0] OFS_COL1    = 4'd4;
  localparam logic [REG_AW-1:0] OFS_COL2    = 4'd5;
  localparam logic [REG_AW-1:0] OFS_SURF_HI = 4'd6;
  localparam logic [REG_AW-1:0] OFS_SURF_LO = 4'd7;

  localparam int CB_EN    = 0;
  localparam int CB_MODE  = 1;
  localparam int CB_MAG   = 3;
  localparam int CB_CLAMP = 4;
  localparam int CB_LOCK  = 8;

  typedef enum logic [1:0] {
    CUR_MONO     = 2'd0,
    CUR_AND_MASK = 2'd1,
    CUR_PREMUL   = 2'd2,
    CUR_STRAIGHT = 2'd3
  } cur_mode_e;

  typedef struct packed {
    logic                 en;
    cur_mode_e            mode;
    logic                 mag;
    logic                 clamp;
    logic [COORD_W-1:0]   px;
    logic [COORD_W-1:0]   py;
    logic [HOT_W-1:0]     hx;
    logic [HOT_W-1:0]     hy;
    logic [SIZE_W-1:0]    wm1;
    logic [SIZE_W-1:0]    hm1;
    logic [COLOR_W-1:0]   col1;
    logic [COLOR_W-1:0]   col2;
    logic [SURF_KEEP-1:0] surf;
  } cur_regs_t;
endpackage

// File: rtl/cursor_host_wr.sv
module cursor_host_wr
  import cursor_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output cur_regs_t         pend,
  output logic              lock,
  output logic              wr_hit
);
  logic [SURF_HI_W-1:0] hi_stage;

  // Every mapped offset except the staged high address marks a pending change
  assign wr_hit = wr_en && (wr_addr <= OFS_SURF_LO) && (wr_addr != OFS_SURF_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= '0;
      lock     <= 1'b0;
      hi_stage <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        OFS_CTRL: begin
          pend.en    <= wr_data[CB_EN];
          pend.mode  <= cur_mode_e'(wr_data[CB_MODE +: 2]);
          pend.mag   <= wr_data[CB_MAG];
          pend.clamp <= wr_data[CB_CLAMP];
          lock       <= wr_data[CB_LOCK];
        end
        OFS_POS: begin
          pend.px <= wr_data[COORD_W-1:0];
          pend.py <= wr_data[HALF +: COORD_W];
        end
        OFS_HOT: begin
          pend.hx <= wr_data[HOT_W-1:0];
          pend.hy <= wr_data[HALF +: HOT_W];
        end
        OFS_SIZE: begin
          pend.wm1 <= wr_data[SIZE_W-1:0];
          pend.hm1 <= wr_data[HALF +: SIZE_W];
        end
        OFS_COL1:    pend.col1 <= wr_data[COLOR_W-1:0];
        OFS_COL2:    pend.col2 <= wr_data[COLOR_W-1:0];
        OFS_SURF_HI: hi_stage  <= wr_data[SURF_HI_W-1:0];
        OFS_SURF_LO: pend.surf <= {hi_stage, wr_data[DATA_W-1:PAGE_BITS]};
        default: ;
      endcase
    end
  end

  // R7: a high-half address write only stages, pending copy untouched
  a_r7_hi_staged_only: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == OFS_SURF_HI) |=> $stable(pend));

  // R12: unmapped offsets leave the pending copy and lock alone
  a_r12_unmapped_quiet: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr > OFS_SURF_LO) |=> ($stable(pend) && $stable(lock)));
endmodule

// File: rtl/cursor_commit_ctl.sv
module cursor_commit_ctl (
  input  logic clk,
  input  logic rst,
  input  logic wr_hit,
  input  logic lock,
  output logic commit_en,
  output logic commit_stb
);
  logic dirty;

  assign commit_en = dirty && !lock;

  always_ff @(posedge clk) begin
    if (rst) begin
      dirty      <= 1'b0;
      commit_stb <= 1'b0;
    end else begin
      if (wr_hit)         dirty <= 1'b1;
      else if (commit_en) dirty <= 1'b0;
      commit_stb <= commit_en;
    end
  end

  // R9: no strobe for an edge at which the lock was held
  a_r9_no_commit_locked: assert property (@(posedge clk) disable iff (rst)
    commit_stb |-> !$past(lock));

  // R10: pending work with the lock clear must produce a commit
  a_r10_release_commits: assert property (@(posedge clk) disable iff (rst)
    ($past(dirty) && !$past(lock)) |-> commit_stb);
endmodule

// File: rtl/cursor_active_regs.sv
module cursor_active_regs
  import cursor_regbank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 commit_en,
  input  cur_regs_t            pend,
  output logic                 cur_enable,
  output logic [1:0]           cur_mode,
  output logic                 cur_magnify,
  output logic                 cur_inv_clamp,
  output logic [COORD_W-1:0]   cur_pos_x,
  output logic [COORD_W-1:0]   cur_pos_y,
  output logic [HOT_W-1:0]     cur_hot_x,
  output logic [HOT_W-1:0]     cur_hot_y,
  output logic [SIZE_W:0]      cur_width,
  output logic [SIZE_W:0]      cur_height,
  output logic [COLOR_W-1:0]   cur_color1,
  output logic [COLOR_W-1:0]   cur_color2,
  output logic [SURF_W-1:0]    cur_surf_addr
);
  localparam logic [SIZE_W:0] ONE = (SIZE_W+1)'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_enable    <= 1'b0;
      cur_mode      <= CUR_MONO;
      cur_magnify   <= 1'b0;
      cur_inv_clamp <= 1'b0;
      cur_pos_x     <= '0;
      cur_pos_y     <= '0;
      cur_hot_x     <= '0;
      cur_hot_y     <= '0;
      cur_width     <= ONE;
      cur_height    <= ONE;
      cur_color1    <= '0;
      cur_color2    <= '0;
      cur_surf_addr <= '0;
    end else if (commit_en) begin
      cur_enable    <= pend.en;
      cur_mode      <= pend.mode;
      cur_magnify   <= pend.mag;
      cur_inv_clamp <= pend.clamp;
      cur_pos_x     <= pend.px;
      cur_pos_y     <= pend.py;
      cur_hot_x     <= pend.hx;
      cur_hot_y     <= pend.hy;
      cur_width     <= {1'b0, pend.wm1} + ONE;
      cur_height    <= {1'b0, pend.hm1} + ONE;
      cur_color1    <= pend.col1;
      cur_color2    <= pend.col2;
      cur_surf_addr <= {pend.surf, {PAGE_BITS{1'b0}}};
    end
  end
endmodule

// File: rtl/cursor_regbank.sv
module cursor_regbank
  import cursor_regbank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [REG_AW-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  output logic                 cur_enable,
  output logic [1:0]           cur_mode,
  output logic                 cur_magnify,
  output logic                 cur_inv_clamp,
  output logic [COORD_W-1:0]   cur_pos_x,
  output logic [COORD_W-1:0]   cur_pos_y,
  output logic [HOT_W-1:0]     cur_hot_x,
  output logic [HOT_W-1:0]     cur_hot_y,
  output logic [SIZE_W:0]      cur_width,
  output logic [SIZE_W:0]      cur_height,
  output logic [COLOR_W-1:0]   cur_color1,
  output logic [COLOR_W-1:0]   cur_color2,
  output logic [SURF_W-1:0]    cur_surf_addr,
  output logic                 commit_stb
);
  cur_regs_t pend;
  logic      lock, wr_hit, commit_en;

  cursor_host_wr u_host (
    .clk, .rst, .wr_en, .wr_addr, .wr_data,
    .pend, .lock, .wr_hit
  );

  cursor_commit_ctl u_commit (
    .clk, .rst, .wr_hit, .lock, .commit_en, .commit_stb
  );

  cursor_active_regs u_active (
    .clk, .rst, .commit_en, .pend,
    .cur_enable, .cur_mode, .cur_magnify, .cur_inv_clamp,
    .cur_pos_x, .cur_pos_y, .cur_hot_x, .cur_hot_y,
    .cur_width, .cur_height, .cur_color1, .cur_color2, .cur_surf_addr
  );

  // R2: active outputs only move in a strobe cycle
  a_r2_change_needs_stb: assert property (@(posedge clk) disable iff (rst)
    !commit_stb |-> $stable({cur_enable, cur_mode, cur_magnify, cur_inv_clamp,
                             cur_pos_x, cur_pos_y, cur_hot_x, cur_hot_y,
                             cur_width, cur_height, cur_color1, cur_color2,
                             cur_surf_addr}));

  // R9: a held lock freezes the active copy
  a_r9_locked_hold: assert property (@(posedge clk) disable iff (rst)
    $past(lock) |-> ($stable(cur_surf_addr) && $stable(cur_width) &&
                     $stable(cur_pos_x) && !commit_stb));
endmodule

// File: tb/test_cursor_regbank.sv
module test_cursor_regbank;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic        cur_enable, cur_magnify, cur_inv_clamp, commit_stb;
  logic [1:0]  cur_mode;
  logic [12:0] cur_pos_x, cur_pos_y;
  logic [6:0]  cur_hot_x, cur_hot_y;
  logic [7:0]  cur_width, cur_height;
  logic [23:0] cur_color1, cur_color2;
  logic [39:0] cur_surf_addr;

  int total = 0;
  int bad   = 0;

  logic        e_en, e_mag, e_clamp;
  logic [1:0]  e_mode;
  logic [12:0] e_px, e_py;
  logic [6:0]  e_hx, e_hy;
  logic [7:0]  e_w, e_h;
  logic [23:0] e_c1, e_c2;
  logic [39:0] e_addr;

  always #5 clk = ~clk;

  cursor_regbank i_cursor_regbank (
    .clk, .rst, .wr_en, .wr_addr, .wr_data,
    .cur_enable, .cur_mode, .cur_magnify, .cur_inv_clamp,
    .cur_pos_x, .cur_pos_y, .cur_hot_x, .cur_hot_y,
    .cur_width, .cur_height, .cur_color1, .cur_color2,
    .cur_surf_addr, .commit_stb
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " enable"}, 64'(cur_enable), 64'(e_en));
    chk({req, " mode"}, 64'(cur_mode), 64'(e_mode));
    chk({req, " magnify"}, 64'(cur_magnify), 64'(e_mag));
    chk({req, " clamp"}, 64'(cur_inv_clamp), 64'(e_clamp));
    chk({req, " pos"}, {38'(cur_pos_x), 13'd0, cur_pos_y}, {38'(e_px), 13'd0, e_py});
    chk({req, " hot"}, 64'({cur_hot_x, cur_hot_y}), 64'({e_hx, e_hy}));
    chk({req, " size"}, 64'({cur_width, cur_height}), 64'({e_w, e_h}));
    chk({req, " col1"}, 64'(cur_color1), 64'(e_c1));
    chk({req, " col2"}, 64'(cur_color2), 64'(e_c2));
    chk({req, " addr"}, 64'(cur_surf_addr), 64'(e_addr));
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [31:0] ctrl_word(input logic en, input logic [1:0] m,
                                            input logic mg, input logic cl, input logic lk);
    return {23'd0, lk, 3'd0, cl, mg, m, en};
  endfunction

  task automatic t_reset();
    chk_all("R1 reset");
    chk("R1 strobe", 64'(commit_stb), 64'd0);
  endtask

  task automatic t_modes();
    for (int m = 0; m < 4; m++) begin
      wr(4'd0, ctrl_word(1'b1, 2'(m), m[0], m[1], 1'b0));
      chk("R2 no strobe at write", 64'(commit_stb), 64'd0);
      tick();
      e_en = 1'b1; e_mode = 2'(m); e_mag = m[0]; e_clamp = m[1];
      chk("R2 strobe", 64'(commit_stb), 64'd1);
      chk_all("R3 mode");
      tick();
      chk("R2 strobe single", 64'(commit_stb), 64'd0);
    end
  endtask

  task automatic t_pos_hot();
    wr(4'd1, {3'b111, 13'h0123, 3'b101, 13'h1abc});
    tick(); e_px = 13'h1abc; e_py = 13'h0123;
    chk_all("R4 pos");
    wr(4'd2, {9'h1ff, 7'h2a, 9'h1ff, 7'h55});
    tick(); e_hx = 7'h55; e_hy = 7'h2a;
    chk_all("R4 hot");
  endtask

  task automatic t_size();
    wr(4'd3, {9'd0, 7'd127, 9'd0, 7'd0});
    tick(); e_w = 8'd1; e_h = 8'd128;
    chk_all("R5 size edges");
    wr(4'd3, {9'h1ff, 7'd0, 9'h1ff, 7'd127});
    tick(); e_w = 8'd128; e_h = 8'd1;
    chk_all("R5 size swap");
  endtask

  task automatic t_colors();
    wr(4'd4, 32'hff112233);
    wr(4'd5, 32'h5aa5b6c7);
    e_c1 = 24'h112233; e_c2 = 24'ha5b6c7;
    tick();
    chk_all("R6 colours");
  endtask

  task automatic t_addr();
    wr(4'd6, 32'hffffffab);
    tick(); tick();
    chk("R7 no strobe", 64'(commit_stb), 64'd0);
    chk_all("R7 hi staged");
    wr(4'd7, 32'h12345fff);
    chk("R8 not yet", 64'(commit_stb), 64'd0);
    tick(); e_addr = 40'hab12345000;
    chk("R8 strobe", 64'(commit_stb), 64'd1);
    chk_all("R8 addr");
  endtask

  task automatic t_lock();
    wr(4'd0, ctrl_word(1'b0, 2'd2, 1'b1, 1'b0, 1'b1));
    wr(4'd1, {3'd0, 13'h0042, 3'd0, 13'h0777});
    wr(4'd3, {9'd0, 7'd31, 9'd0, 7'd63});
    wr(4'd4, 32'h00c0ffee);
    wr(4'd6, 32'h00000012);
    wr(4'd7, 32'hfedcb000);
    tick(); tick();
    chk("R9 no strobe", 64'(commit_stb), 64'd0);
    chk_all("R9 held");
    wr(4'd0, ctrl_word(1'b1, 2'd3, 1'b0, 1'b1, 1'b0));
    chk("R10 not yet", 64'(commit_stb), 64'd0);
    tick();
    e_en = 1'b1; e_mode = 2'd3; e_mag = 1'b0; e_clamp = 1'b1;
    e_px = 13'h0777; e_py = 13'h0042; e_w = 8'd64; e_h = 8'd32;
    e_c1 = 24'hc0ffee; e_addr = 40'h12fedcb000;
    chk("R10 strobe", 64'(commit_stb), 64'd1);
    chk_all("R10 release");
    tick();
    chk("R10 single strobe", 64'(commit_stb), 64'd0);
  endtask

  task automatic t_coincide();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd1; wr_data = {3'd0, 13'h0011, 3'd0, 13'h0022};
    @(negedge clk);
    wr_data = {3'd0, 13'h0033, 3'd0, 13'h0044};
    @(negedge clk);
    wr_en = 1'b0;
    e_px = 13'h0022; e_py = 13'h0011;
    chk("R11 first strobe", 64'(commit_stb), 64'd1);
    chk_all("R11 first");
    tick();
    e_px = 13'h0044; e_py = 13'h0033;
    chk("R11 second strobe", 64'(commit_stb), 64'd1);
    chk_all("R11 second");
    tick();
    chk("R11 quiet", 64'(commit_stb), 64'd0);
  endtask

  task automatic t_unmapped();
    for (int a = 8; a < 16; a++) wr(4'(a), 32'hffffffff);
    tick(); tick();
    chk("R12 no strobe", 64'(commit_stb), 64'd0);
    chk_all("R12 outputs");
    wr(4'd0, ctrl_word(1'b0, 2'd1, 1'b1, 1'b1, 1'b0));
    tick();
    e_en = 1'b0; e_mode = 2'd1; e_mag = 1'b1; e_clamp = 1'b1;
    chk_all("R12 pending intact");
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    e_en = 0; e_mode = 0; e_mag = 0; e_clamp = 0;
    e_px = 0; e_py = 0; e_hx = 0; e_hy = 0; e_w = 8'd1; e_h = 8'd1;
    e_c1 = 0; e_c2 = 0; e_addr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();
    t_reset();
    t_modes();
    t_pos_hot();
    t_size();
    t_colors();
    t_addr();
    t_lock();
    t_coincide();
    t_unmapped();
    finish_up();
  end
endmodule